// File: doc/BRIEF.md
# BCD Time-of-Day Calendar with Alarm

This core keeps wall-clock time for a chip that has a slow, always-on timebase. A prescaler counts pulses on a slow tick input. Every `TICKS_PER_SEC` pulses it produces a one-second step. That step advances a seconds/minutes/hours counter, held in packed BCD, and a free-running 15-bit binary day number. The block does not convert the day number to a calendar date; software does that.

Software reaches the core through a byte-wide register port with a single-cycle write strobe and a combinational read path. Through it, software sets the time, programs an alarm and controls the block. The alarm compares a minute, an hour and a day value against the time. Each of the three has its own match enable. The comparison is made only at the moment the seconds roll over to 00. A hit sets a sticky flag, which software clears by writing one to it. The flag drives an interrupt line when the interrupt enable is set.

A busy bit tells software that a one-second update is in progress. Writes to time registers made during those cycles are dropped.

Top module: `rtc_cal_core`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00 and `alarm_irq` is low.
- R2: The register map is: control 0x0, seconds 0x1, minutes 0x2, hours 0x3, day bits 7:0 at 0x4, day bits 14:8 at 0x5, alarm minute 0x6, alarm hour 0x7, alarm day bits 7:0 at 0x8, alarm day bits 14:8 at 0x9.
- R3: With run enable (control bit 0) set, the seconds register steps once per `TICKS_PER_SEC` pulses of `osc_tick` and counts in packed BCD from 0x00 to 0x59 (for example 0x09 is followed by 0x10).
- R4: When seconds go from 0x59 to 0x00, minutes step in BCD. Minutes go 0x59 to 0x00 with a carry into hours, and hours go 0x23 to 0x00.
- R5: The day number is binary, 15 bits wide. It steps when hours wrap, and 0x7FFF wraps to 0x0000.
- R6: While run enable is clear, `osc_tick` pulses change no time register.
- R7: A write to any time register (0x1 to 0x5) takes effect on the next clock and restarts the prescaler from zero.
- R8: Control bit 7 (busy, read-only) reads 1 while a one-second update is in progress. A time-register write made while busy is ignored.
- R9: When seconds roll to 0x00, the alarm flag (control bit 2) is set if every enabled field matches the new time. The enables are minute (bit 3), hour (bit 4) and day (bit 5).
- R10: With no match enable set, the alarm flag is never set.
- R11: The alarm is evaluated only at the seconds rollover. A match that persists through the rest of that minute does not set the flag again after it is cleared.
- R12: Writing the control register with bit 2 = 1 clears the flag. Writing bit 2 = 0 leaves it unchanged.
- R13: `alarm_irq` is high exactly when the flag is set and alarm interrupt enable (control bit 1) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse from the slow timebase |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The bench targets these corner cases:
- **Full rollover.** 23:59:59 on day 0x7FFF must step to 00:00:00 on day 0. A broken carry chain would leave one field stuck or step it twice.
- **Prescaler restart.** A write placed three pulses into a second must push the next step out by a whole second. A design that kept its prescaler count would step too early.
- **Write during busy.** A seconds write that collides with an update must be dropped, so the incremented value is read back. A design that let the write through would show the written value.
- **Alarm edge cases.** The bench checks a hour mismatch, a day match that relies on the freshly carried day, and an alarm with no enables. It also checks a cleared flag that must stay clear while the minute still matches. A design that compared continuously would re-raise the flag.
- **Write-zero and gating.** A design that cleared the flag on any control write, or ignored the interrupt enable, is caught by the write-zero and gating checks.

// File: rtl/rtc_cal_pkg.sv
// Shared constants for the BCD calendar core.
// Assumes byte-wide register addressing; field widths match packed BCD ranges.
package rtc_cal_pkg;

    // register addresses
    localparam logic [7:0] ADR_CTRL  = 8'h00;
    localparam logic [7:0] ADR_SEC   = 8'h01;
    localparam logic [7:0] ADR_MIN   = 8'h02;
    localparam logic [7:0] ADR_HOUR  = 8'h03;
    localparam logic [7:0] ADR_DLO   = 8'h04;
    localparam logic [7:0] ADR_DHI   = 8'h05;
    localparam logic [7:0] ADR_AMIN  = 8'h06;
    localparam logic [7:0] ADR_AHOUR = 8'h07;
    localparam logic [7:0] ADR_ADLO  = 8'h08;
    localparam logic [7:0] ADR_ADHI  = 8'h09;

    // control register bit positions
    localparam int CB_RUN  = 0;
    localparam int CB_AIEN = 1;
    localparam int CB_FLAG = 2;
    localparam int CB_MEN  = 3;
    localparam int CB_HEN  = 4;
    localparam int CB_DEN  = 5;
    localparam int CB_BUSY = 7;

    // field widths
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DAY_W  = 15;
    localparam int DHI_W  = DAY_W - 8;

    // last legal BCD values
    localparam logic [7:0] SEC_LAST  = 8'h59;
    localparam logic [7:0] MIN_LAST  = 8'h59;
    localparam logic [7:0] HOUR_LAST = 8'h23;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_CARRY = 1'b1
    } seq_t;

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the slow tick into a one-second pulse.
// Assumes osc_tick is a single-cycle pulse; restart has priority over counting.
module rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic osc_tick,
    input  logic restart,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    // count slow ticks and emit one pulse per full second
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sec_pulse <= 1'b0;
        end else begin
            sec_pulse <= 1'b0;
            if (restart) begin
                cnt_q <= '0;
            end else if (run && osc_tick) begin
                if (cnt_q == LAST) begin
                    cnt_q     <= '0;
                    sec_pulse <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rtc_bcd_field.sv
// Next-value logic for one packed-BCD field with wrap at LAST.
// Assumes the current value is valid BCD; anything at or above LAST wraps to zero.
module rtc_bcd_field #(
    parameter logic [7:0] LAST = 8'h59
) (
    input  logic [7:0] cur,
    output logic [7:0] nxt,
    output logic       wrap
);
    // BCD increment with decade carry and wrap
    always_comb begin
        wrap = (cur >= LAST);
        if (wrap) begin
            nxt = 8'h00;
        end else if (cur[3:0] >= 4'd9) begin
            nxt = {cur[7:4] + 4'd1, 4'd0};
        end else begin
            nxt = cur + 8'd1;
        end
    end
endmodule

// File: rtl/rtc_alarm_match.sv
// Compares candidate time against the alarm with per-field enables.
// Assumes at least one enable must be set for a hit.
module rtc_alarm_match
    import rtc_cal_pkg::*;
(
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic [MIN_W-1:0]  al_min,
    input  logic [HOUR_W-1:0] al_hour,
    input  logic [DAY_W-1:0]  al_day,
    input  logic              en_min,
    input  logic              en_hour,
    input  logic              en_day,
    output logic              hit
);
    // every enabled field must agree, and something must be enabled
    always_comb begin
        hit = (en_min || en_hour || en_day)
           && (!en_min  || (cur_min  == al_min))
           && (!en_hour || (cur_hour == al_hour))
           && (!en_day  || (cur_day  == al_day));
    end
endmodule

// File: rtl/rtc_cal_core.sv
// Time-of-day calendar: BCD sec/min/hour, binary day, alarm and register port.
// Assumes reg_wr is a single-cycle strobe; reads are combinational on reg_addr.
module rtc_cal_core
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_tick,
    input  logic       reg_wr,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       alarm_irq
);
    logic [SEC_W-1:0]  sec_q;
    logic [MIN_W-1:0]  min_q;
    logic [HOUR_W-1:0] hour_q;
    logic [DAY_W-1:0]  day_q;
    logic [MIN_W-1:0]  amin_q;
    logic [HOUR_W-1:0] ahour_q;
    logic [DAY_W-1:0]  aday_q;
    logic run_q, aien_q, flag_q, men_q, hen_q, den_q;
    seq_t seq_q;

    logic sec_pulse, busy, is_time_adr, time_wr, ctrl_wr, alarm_hit, set_flag;
    logic [7:0] sec_nxt, min_nxt, hour_nxt;
    logic sec_wrap, min_wrap, hour_wrap;
    logic [MIN_W-1:0]  min_new;
    logic [HOUR_W-1:0] hour_new;
    logic [DAY_W-1:0]  day_new;

    rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run_q), .osc_tick(osc_tick),
        .restart(time_wr), .sec_pulse(sec_pulse)
    );

    rtc_bcd_field #(.LAST(SEC_LAST)) u_sec (
        .cur({{(8-SEC_W){1'b0}}, sec_q}), .nxt(sec_nxt), .wrap(sec_wrap)
    );
    rtc_bcd_field #(.LAST(MIN_LAST)) u_min (
        .cur({{(8-MIN_W){1'b0}}, min_q}), .nxt(min_nxt), .wrap(min_wrap)
    );
    rtc_bcd_field #(.LAST(HOUR_LAST)) u_hour (
        .cur({{(8-HOUR_W){1'b0}}, hour_q}), .nxt(hour_nxt), .wrap(hour_wrap)
    );

    // decode the register strobe and the busy window
    always_comb begin
        busy        = sec_pulse || (seq_q == SEQ_CARRY);
        is_time_adr = (reg_addr == ADR_SEC) || (reg_addr == ADR_MIN) ||
                      (reg_addr == ADR_HOUR) || (reg_addr == ADR_DLO) ||
                      (reg_addr == ADR_DHI);
        time_wr     = reg_wr && is_time_adr && !busy;
        ctrl_wr     = reg_wr && (reg_addr == ADR_CTRL);
    end

    // values the minute/hour/day fields take in the carry cycle
    always_comb begin
        min_new  = min_nxt[MIN_W-1:0];
        hour_new = min_wrap ? hour_nxt[HOUR_W-1:0] : hour_q;
        day_new  = (min_wrap && hour_wrap) ? day_q + 1'b1 : day_q;
    end

    rtc_alarm_match u_match (
        .cur_min(min_new), .cur_hour(hour_new), .cur_day(day_new),
        .al_min(amin_q), .al_hour(ahour_q), .al_day(aday_q),
        .en_min(men_q), .en_hour(hen_q), .en_day(den_q),
        .hit(alarm_hit)
    );

    assign set_flag = (seq_q == SEQ_CARRY) && alarm_hit;

    // two-step update sequencer: seconds first, then the carry into minutes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
        end else if (sec_pulse && sec_wrap) begin
            seq_q <= SEQ_CARRY;
        end else begin
            seq_q <= SEQ_IDLE;
        end
    end

    // time registers: software writes or tick-driven updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
            day_q  <= '0;
        end else if (time_wr) begin
            case (reg_addr)
                ADR_SEC:  sec_q  <= reg_wdata[SEC_W-1:0];
                ADR_MIN:  min_q  <= reg_wdata[MIN_W-1:0];
                ADR_HOUR: hour_q <= reg_wdata[HOUR_W-1:0];
                ADR_DLO:  day_q[7:0] <= reg_wdata;
                ADR_DHI:  day_q[DAY_W-1:8] <= reg_wdata[DHI_W-1:0];
                default:  ;
            endcase
        end else if (sec_pulse) begin
            sec_q <= sec_nxt[SEC_W-1:0];
        end else if (seq_q == SEQ_CARRY) begin
            min_q  <= min_new;
            hour_q <= hour_new;
            day_q  <= day_new;
        end
    end

    // alarm compare registers, writable at any time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            amin_q  <= '0;
            ahour_q <= '0;
            aday_q  <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADR_AMIN:  amin_q  <= reg_wdata[MIN_W-1:0];
                ADR_AHOUR: ahour_q <= reg_wdata[HOUR_W-1:0];
                ADR_ADLO:  aday_q[7:0] <= reg_wdata;
                ADR_ADHI:  aday_q[DAY_W-1:8] <= reg_wdata[DHI_W-1:0];
                default:   ;
            endcase
        end
    end

    // control bits; an alarm set beats a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            aien_q <= 1'b0;
            men_q  <= 1'b0;
            hen_q  <= 1'b0;
            den_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                run_q  <= reg_wdata[CB_RUN];
                aien_q <= reg_wdata[CB_AIEN];
                men_q  <= reg_wdata[CB_MEN];
                hen_q  <= reg_wdata[CB_HEN];
                den_q  <= reg_wdata[CB_DEN];
            end
            if (set_flag) begin
                flag_q <= 1'b1;
            end else if (ctrl_wr && reg_wdata[CB_FLAG]) begin
                flag_q <= 1'b0;
            end
        end
    end

    // read mux
    always_comb begin
        reg_rdata = 8'h00;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CB_RUN]  = run_q;
                reg_rdata[CB_AIEN] = aien_q;
                reg_rdata[CB_FLAG] = flag_q;
                reg_rdata[CB_MEN]  = men_q;
                reg_rdata[CB_HEN]  = hen_q;
                reg_rdata[CB_DEN]  = den_q;
                reg_rdata[CB_BUSY] = busy;
            end
            ADR_SEC:   reg_rdata = 8'(sec_q);
            ADR_MIN:   reg_rdata = 8'(min_q);
            ADR_HOUR:  reg_rdata = 8'(hour_q);
            ADR_DLO:   reg_rdata = day_q[7:0];
            ADR_DHI:   reg_rdata = 8'(day_q[DAY_W-1:8]);
            ADR_AMIN:  reg_rdata = 8'(amin_q);
            ADR_AHOUR: reg_rdata = 8'(ahour_q);
            ADR_ADLO:  reg_rdata = aday_q[7:0];
            ADR_ADHI:  reg_rdata = 8'(aday_q[DAY_W-1:8]);
            default:   reg_rdata = 8'h00;
        endcase
    end

    assign alarm_irq = flag_q && aien_q;

endmodule

// File: rtl/rtc_cal_core_chk.sv
// Protocol checks for the calendar core, attached by bind.
// Assumes the synchronous reset is held for at least one clock at start.
module rtc_cal_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_pulse,
    input logic       time_wr,
    input logic       carry_stage,
    input logic       run_q,
    input logic       flag_q,
    input logic       any_en,
    input logic [6:0] sec_q
);
    // seconds only move on a step or an accepted write
    p_sec_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q != $past(sec_q)) |-> ($past(sec_pulse) || $past(time_wr)));

    // no one-second step when run was off
    p_no_step_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_q) |-> !sec_pulse);

    // carry stage lasts a single cycle
    p_busy_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_stage |=> !carry_stage);

    // flag rises only right after a carry stage
    p_flag_at_rollover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(carry_stage));

    // flag needs an enabled field
    p_flag_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(any_en));
endmodule

bind rtc_cal_core rtc_cal_core_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .sec_pulse(sec_pulse),
    .time_wr(time_wr),
    .carry_stage(seq_q == rtc_cal_pkg::SEQ_CARRY),
    .run_q(run_q),
    .flag_q(flag_q),
    .any_en(men_q || hen_q || den_q),
    .sec_q(sec_q)
);

// File: tb/rtc_cal_core_test.sv
`timescale 1ns/1ps
module rtc_cal_core_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       alarm_irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_cal_core #(.TICKS_PER_SEC(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic pulse_osc();
        osc_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic adv_sec();
        for (int i = 0; i < DIV; i++) pulse_osc();
        settle();
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                            input logic [7:0] dlo, input logic [7:0] dhi);
        wr(8'h03, h); wr(8'h02, m); wr(8'h04, dlo); wr(8'h05, dhi); wr(8'h01, s);
    endtask

    // R1 and R2: reset state across the whole map
    task automatic t_reset();
        logic [7:0] v;
        for (int a = 0; a < 10; a++) begin
            rd(8'(a), v);
            check($sformatf("R1 R2 reg %0d after reset", a), v, 8'h00);
        end
        check("R1 irq after reset", {7'd0, alarm_irq}, 8'h00);
    endtask

    // R3: BCD seconds stepping
    task automatic t_seconds();
        logic [7:0] v;
        wr(8'h00, 8'h01);
        set_time(8'h00, 8'h00, 8'h08, 8'h00, 8'h00);
        adv_sec(); rd(8'h01, v); check("R3 sec 08->09", v, 8'h09);
        adv_sec(); rd(8'h01, v); check("R3 sec 09->10", v, 8'h10);
    endtask

    // R4 and R5: full carry chain and day wrap
    task automatic t_rollover();
        logic [7:0] v;
        set_time(8'h23, 8'h59, 8'h59, 8'hFF, 8'h7F);
        adv_sec();
        rd(8'h01, v); check("R4 sec wrap", v, 8'h00);
        rd(8'h02, v); check("R4 min wrap", v, 8'h00);
        rd(8'h03, v); check("R4 hour wrap", v, 8'h00);
        rd(8'h04, v); check("R5 day lo wrap", v, 8'h00);
        rd(8'h05, v); check("R5 day hi wrap", v, 8'h00);
        set_time(8'h12, 8'h59, 8'h59, 8'hFF, 8'h00);
        adv_sec();
        rd(8'h03, v); check("R4 hour 12->13", v, 8'h13);
        rd(8'h04, v); check("R5 day lo unchanged", v, 8'hFF);
        set_time(8'h23, 8'h59, 8'h59, 8'hFF, 8'h00);
        adv_sec();
        rd(8'h04, v); check("R5 day lo carry", v, 8'h00);
        rd(8'h05, v); check("R5 day hi carry", v, 8'h01);
    endtask

    // R6: no stepping while stopped
    task automatic t_stopped();
        logic [7:0] v;
        wr(8'h00, 8'h00);
        set_time(8'h01, 8'h02, 8'h03, 8'h00, 8'h00);
        adv_sec(); adv_sec();
        rd(8'h01, v); check("R6 sec frozen", v, 8'h03);
        wr(8'h00, 8'h01);
    endtask

    // R7: write restarts the prescaler
    task automatic t_restart();
        logic [7:0] v;
        wr(8'h01, 8'h10);
        for (int i = 0; i < DIV - 1; i++) pulse_osc();
        wr(8'h01, 8'h20);
        rd(8'h01, v); check("R7 write immediate", v, 8'h20);
        for (int i = 0; i < DIV - 1; i++) pulse_osc();
        settle();
        rd(8'h01, v); check("R7 no early step", v, 8'h20);
        pulse_osc(); settle();
        rd(8'h01, v); check("R7 step after full second", v, 8'h21);
    endtask

    // R8: busy flag and dropped write
    task automatic t_busy();
        logic [7:0] v;
        wr(8'h01, 8'h30);
        for (int i = 0; i < DIV; i++) pulse_osc();
        rd(8'h00, v); check("R8 busy during update", v & 8'h80, 8'h80);
        wr(8'h01, 8'h45);
        settle();
        rd(8'h01, v); check("R8 write during busy ignored", v, 8'h31);
        rd(8'h00, v); check("R8 busy cleared", v & 8'h80, 8'h00);
    endtask

    // R9-R13: alarm behaviour
    task automatic t_alarm();
        logic [7:0] v;
        wr(8'h06, 8'h05);
        wr(8'h00, 8'h0F);                       // run, aien, minute enable, clear flag
        set_time(8'h10, 8'h04, 8'h59, 8'h00, 8'h00);
        adv_sec();
        rd(8'h00, v); check("R9 minute match sets flag", v, 8'h0F);
        check("R13 irq with aien", {7'd0, alarm_irq}, 8'h01);
        wr(8'h00, 8'h0F);
        rd(8'h00, v); check("R12 W1C clears flag", v, 8'h0B);
        check("R13 irq drops", {7'd0, alarm_irq}, 8'h00);
        adv_sec();
        rd(8'h00, v); check("R11 no retrigger in minute", v, 8'h0B);
        set_time(8'h10, 8'h04, 8'h59, 8'h00, 8'h00);
        adv_sec();
        wr(8'h00, 8'h0B);
        rd(8'h00, v); check("R12 write 0 keeps flag", v, 8'h0F);
        wr(8'h00, 8'h09);
        rd(8'h00, v); check("R13 flag kept, aien off", v, 8'h0D);
        check("R13 irq gated off", {7'd0, alarm_irq}, 8'h00);
        // hour enabled too
        wr(8'h07, 8'h11);
        wr(8'h00, 8'h1D);
        set_time(8'h10, 8'h04, 8'h59, 8'h00, 8'h00);
        adv_sec();
        rd(8'h00, v); check("R9 hour mismatch no flag", v, 8'h19);
        set_time(8'h11, 8'h04, 8'h59, 8'h00, 8'h00);
        adv_sec();
        rd(8'h00, v); check("R9 hour and minute match", v, 8'h1D);
        // nothing enabled
        wr(8'h00, 8'h05);
        set_time(8'h11, 8'h04, 8'h59, 8'h00, 8'h00);
        adv_sec();
        rd(8'h00, v); check("R10 no enable no flag", v, 8'h01);
        // day enable against freshly carried day
        wr(8'h08, 8'h03); wr(8'h09, 8'h00);
        wr(8'h00, 8'h25);
        set_time(8'h23, 8'h59, 8'h59, 8'h02, 8'h00);
        adv_sec();
        rd(8'h00, v); check("R9 day match on carry", v, 8'h25);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_rollover();
        t_stopped();
        t_restart();
        t_busy();
        t_alarm();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule